// File: doc/BRIEF.md
# Vector configuration and length setter

This block carries out the configuration step of a vector unit. A request brings two things: an application vector length (AVL) read from a scalar register, and a 7-bit type immediate. From the immediate the block takes three settings: the element width, the register-group multiplier and the element divider. It checks that the setting is legal for the elaboration parameters `VLEN` (bits per vector register) and `ELEN` (widest element). It then computes the largest length the setting allows and grants the smaller of that and the AVL.

The granted length is stored as the active length. One cycle after the request it is also returned as a scalar result, so a strip-mining loop can advance its pointers and count down its remaining work. A legal setting also clears the resume-element index. A trap handler can load that index through a separate write port.

Top module: `vcfg_setter`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_illegal`, `rsp_vl`, `vl`, `vstart`, `vsew`, `vlmul` and `vediv` are all zero.
- R2: Immediate bits [4:2] give the width code w, with SEW = 8 << w. Bits [1:0] give the group code m, with LMUL = 1 << m. Bits [6:5] give the divider code d, with EDIV = 1 << d. After a legal request, `vsew`, `vlmul` and `vediv` show w, m and d. Immediate bits [10:7] have no effect on any output.
- R3: The maximum length is VLMAX = LMUL * VLEN / SEW, computed with shifts. With VLEN = 512, SEW = 32 and LMUL = 1, a very large AVL is granted 16.
- R4: For a legal request, `vl` becomes min(AVL, VLMAX), where AVL is compared as an unsigned value. It never exceeds VLMAX.
- R5: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. In that cycle `rsp_vl` holds the granted length, zero-extended.
- R6: A setting is illegal when SEW > ELEN or when SEW / EDIV < 1. An illegal request sets `rsp_illegal` for that response, forces `vl` and `rsp_vl` to 0, and leaves `vsew`, `vlmul`, `vediv` and `vstart` unchanged.
- R7: A legal request sets `vstart` to 0. It takes priority over a `vstart_wr` in the same cycle.
- R8: When `vstart_wr` is high and no request is present, `vstart` takes `vstart_val` at the next edge.
- R9: In a cycle with neither a request nor a `vstart_wr`, `vl`, `vsew`, `vlmul`, `vediv`, `vstart` and `rsp_vl` keep their values, and `rsp_valid` and `rsp_illegal` are low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration request strobe |
| req_avl | input | XLEN | Requested application vector length |
| req_imm | input | 11 | Type immediate |
| vstart_wr | input | 1 | Load strobe for the resume-element index |
| vstart_val | input | VL_W | Value loaded into the resume-element index |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_illegal | output | 1 | The answered request had an illegal setting |
| rsp_vl | output | XLEN | Granted length for the scalar destination |
| vl | output | VL_W | Active vector length |
| vsew | output | 3 | Current element-width code |
| vlmul | output | 2 | Current group-multiplier code |
| vediv | output | 2 | Current divider code |
| vstart | output | VL_W | Resume-element index |

## Verification
The bench sweeps all 128 type immediates. For each one it applies AVLs of zero, one, VLMAX-1, VLMAX, VLMAX+1 and all-ones, so every clamp boundary is hit for every group and width. A shift amount that is off by one would halve or double the grant. A comparison done in a truncated width would grant wrapped lengths for the all-ones AVL. A `<=` swapped for `<` would misreport the VLMAX boundary. Illegal widths are followed by checks that the type fields and the resume index kept their old values, which catches a design that commits a rejected setting. The priority between a request and a resume-index write in the same cycle is checked, as is the hold of all state when the block is idle.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    // Immediate layout
    localparam int IMM_W       = 11;
    localparam int IMM_USED    = 7;
    localparam int SEW_CODE_W  = 3;
    localparam int LMUL_CODE_W = 2;
    localparam int EDIV_CODE_W = 2;
    localparam int LMUL_LSB    = 0;
    localparam int SEW_LSB     = 2;
    localparam int EDIV_LSB    = 5;

    // Smallest element width is 2**SEW_BASE_LOG2 bits
    localparam int SEW_BASE_LOG2 = 3;

    typedef struct packed {
        logic [SEW_CODE_W-1:0]  sew;
        logic [LMUL_CODE_W-1:0] lmul;
        logic [EDIV_CODE_W-1:0] ediv;
    } vtype_t;

endpackage

// File: rtl/vcfg_imm_decode.sv
module vcfg_imm_decode
    import vcfg_pkg::*;
(
    input  logic [IMM_USED-1:0] imm,
    output vtype_t              vt
);

    always_comb begin
        vt.sew  = imm[SEW_LSB  +: SEW_CODE_W];
        vt.lmul = imm[LMUL_LSB +: LMUL_CODE_W];
        vt.ediv = imm[EDIV_LSB +: EDIV_CODE_W];
    end

endmodule

// File: rtl/vcfg_legal.sv
module vcfg_legal
    import vcfg_pkg::*;
#(
    parameter int ELEN = 64
) (
    input  vtype_t vt,
    output logic   ok
);

    localparam int ELEN_LOG2 = $clog2(ELEN);

    int sew_log2;

    always_comb begin
        sew_log2 = SEW_BASE_LOG2 + int'(vt.sew);
        // width must fit ELEN, and each sub-element must keep at least one bit
        ok = (sew_log2 <= ELEN_LOG2) && (sew_log2 >= int'(vt.ediv));
    end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
    import vcfg_pkg::*;
#(
    parameter int VLEN = 512,
    parameter int VL_W = 10
) (
    input  vtype_t          vt,
    output logic [VL_W-1:0] vlmax
);

    localparam int MAX_LMUL_LOG2 = (1 << LMUL_CODE_W) - 1;
    localparam int WIDE          = VL_W + MAX_LMUL_LOG2;
    localparam int SH_W          = $clog2(SEW_BASE_LOG2 + (1 << SEW_CODE_W));

    logic [WIDE-1:0] grouped_bits;
    logic [WIDE-1:0] scaled;
    logic [SH_W-1:0] sew_shift;
    logic            unused_scaled_hi;

    always_comb begin
        sew_shift    = SH_W'(SEW_BASE_LOG2) + SH_W'(vt.sew);
        grouped_bits = WIDE'(VLEN) << vt.lmul;
        scaled       = grouped_bits >> sew_shift;
        vlmax        = scaled[VL_W-1:0];
    end

    assign unused_scaled_hi = |scaled[WIDE-1:VL_W];

endmodule

// File: rtl/vcfg_clamp.sv
module vcfg_clamp #(
    parameter int XLEN = 32,
    parameter int VL_W = 10
) (
    input  logic [XLEN-1:0] avl,
    input  logic [VL_W-1:0] vlmax,
    input  logic            ok,
    output logic [VL_W-1:0] grant
);

    always_comb begin
        if (!ok) begin
            grant = '0;
        end else if (avl < XLEN'(vlmax)) begin
            grant = avl[VL_W-1:0];
        end else begin
            grant = vlmax;
        end
    end

endmodule

// File: rtl/vcfg_setter.sv
module vcfg_setter
    import vcfg_pkg::*;
#(
    parameter  int VLEN = 512,
    parameter  int ELEN = 64,
    parameter  int XLEN = 32,
    localparam int VL_W = $clog2(VLEN) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [XLEN-1:0]        req_avl,
    input  logic [IMM_W-1:0]       req_imm,
    input  logic                   vstart_wr,
    input  logic [VL_W-1:0]        vstart_val,
    output logic                   rsp_valid,
    output logic                   rsp_illegal,
    output logic [XLEN-1:0]        rsp_vl,
    output logic [VL_W-1:0]        vl,
    output logic [SEW_CODE_W-1:0]  vsew,
    output logic [LMUL_CODE_W-1:0] vlmul,
    output logic [EDIV_CODE_W-1:0] vediv,
    output logic [VL_W-1:0]        vstart
);

    typedef struct packed {
        vtype_t          vt;
        logic [VL_W-1:0] vl;
        logic [VL_W-1:0] vstart;
        logic [XLEN-1:0] rd;
        logic            rsp_valid;
        logic            rsp_illegal;
    } state_t;

    vtype_t          dec_vt;
    logic            cfg_ok;
    logic [VL_W-1:0] vlmax_w;
    logic [VL_W-1:0] grant_w;
    logic            unused_imm_hi;
    state_t          st_d;
    state_t          st_q;

    assign unused_imm_hi = |req_imm[IMM_W-1:IMM_USED];

    vcfg_imm_decode u_dec (
        .imm (req_imm[IMM_USED-1:0]),
        .vt  (dec_vt)
    );

    vcfg_legal #(.ELEN(ELEN)) u_legal (
        .vt (dec_vt),
        .ok (cfg_ok)
    );

    vcfg_vlmax #(.VLEN(VLEN), .VL_W(VL_W)) u_vlmax (
        .vt    (dec_vt),
        .vlmax (vlmax_w)
    );

    vcfg_clamp #(.XLEN(XLEN), .VL_W(VL_W)) u_clamp (
        .avl   (req_avl),
        .vlmax (vlmax_w),
        .ok    (cfg_ok),
        .grant (grant_w)
    );

    always_comb begin
        st_d             = st_q;
        st_d.rsp_valid   = req_valid;
        st_d.rsp_illegal = 1'b0;
        if (vstart_wr) begin
            st_d.vstart = vstart_val;
        end
        if (req_valid) begin
            st_d.rsp_illegal = !cfg_ok;
            st_d.vl          = grant_w;
            st_d.rd          = XLEN'(grant_w);
            if (cfg_ok) begin
                st_d.vt     = dec_vt;
                st_d.vstart = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_illegal = st_q.rsp_illegal;
    assign rsp_vl      = st_q.rd;
    assign vl          = st_q.vl;
    assign vsew        = st_q.vt.sew;
    assign vlmul       = st_q.vt.lmul;
    assign vediv       = st_q.vt.ediv;
    assign vstart      = st_q.vstart;

endmodule

// File: rtl/vcfg_setter_chk.sv
module vcfg_setter_chk
    import vcfg_pkg::*;
#(
    parameter  int VLEN = 512,
    parameter  int ELEN = 64,
    parameter  int XLEN = 32,
    localparam int VL_W = $clog2(VLEN) + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   vstart_wr,
    input logic                   rsp_valid,
    input logic                   rsp_illegal,
    input logic [XLEN-1:0]        rsp_vl,
    input logic [VL_W-1:0]        vl,
    input logic [SEW_CODE_W-1:0]  vsew,
    input logic [LMUL_CODE_W-1:0] vlmul,
    input logic [EDIV_CODE_W-1:0] vediv,
    input logic [VL_W-1:0]        vstart
);

    // R5
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R5
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5
    rd_matches_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_vl == XLEN'(vl)));

    // R4
    vl_within_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal) |->
            (XLEN'(vl) <= (XLEN'(VLEN) << vlmul) >> (SEW_BASE_LOG2 + int'(vsew))));

    // R6
    illegal_keeps_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |->
            (vl == '0 && $stable(vsew) && $stable(vlmul) && $stable(vediv) && $stable(vstart)));

    // R7
    legal_clears_vstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal) |-> (vstart == '0));

    // R9
    idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !vstart_wr) |=>
            ($stable(vl) && $stable(vsew) && $stable(vlmul) && $stable(vediv)
             && $stable(vstart) && $stable(rsp_vl) && !rsp_illegal));

endmodule

bind vcfg_setter vcfg_setter_chk #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .vstart_wr   (vstart_wr),
    .rsp_valid   (rsp_valid),
    .rsp_illegal (rsp_illegal),
    .rsp_vl      (rsp_vl),
    .vl          (vl),
    .vsew        (vsew),
    .vlmul       (vlmul),
    .vediv       (vediv),
    .vstart      (vstart)
);

// File: tb/vcfg_setter_test.sv
`timescale 1ns/1ps
module vcfg_setter_test;

    localparam int VLEN = 512;
    localparam int ELEN = 64;
    localparam int XLEN = 32;
    localparam int VL_W = $clog2(VLEN) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [XLEN-1:0] req_avl = '0;
    logic [10:0]     req_imm = '0;
    logic            vstart_wr = 1'b0;
    logic [VL_W-1:0] vstart_val = '0;
    logic            rsp_valid;
    logic            rsp_illegal;
    logic [XLEN-1:0] rsp_vl;
    logic [VL_W-1:0] vl;
    logic [2:0]      vsew;
    logic [1:0]      vlmul;
    logic [1:0]      vediv;
    logic [VL_W-1:0] vstart;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model of the type state
    int m_sew  = 0;
    int m_lmul = 0;
    int m_ediv = 0;
    int m_vstart = 0;

    always #2 clk = ~clk;

    vcfg_setter #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
        .req_imm(req_imm), .vstart_wr(vstart_wr), .vstart_val(vstart_val),
        .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_vl(rsp_vl),
        .vl(vl), .vsew(vsew), .vlmul(vlmul), .vediv(vediv), .vstart(vstart)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint max_len(int s, int m);
        return (longint'(VLEN) << m) / (longint'(8) << s);
    endfunction

    // entered and left at a falling edge
    task automatic do_req(logic [10:0] imm, logic [XLEN-1:0] avl);
        int s, m, d;
        bit legal;
        longint vmax, exp_vl;
        s = int'(imm[4:2]);
        m = int'(imm[1:0]);
        d = int'(imm[6:5]);
        legal = ((8 << s) <= ELEN) && ((8 << s) >= (1 << d));
        vmax = max_len(s, m);
        exp_vl = !legal ? 0 : (longint'(avl) < vmax ? longint'(avl) : vmax);
        req_imm = imm;
        req_avl = avl;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (legal) begin
            m_sew = s; m_lmul = m; m_ediv = d; m_vstart = 0;
        end
        chk("R5 rsp_valid", rsp_valid, 1);
        chk("R6 rsp_illegal", rsp_illegal, legal ? 0 : 1);
        chk("R4 vl", vl, exp_vl);
        chk("R5 rsp_vl", rsp_vl, exp_vl);
        chk("R2 vsew", vsew, m_sew);
        chk("R2 vlmul", vlmul, m_lmul);
        chk("R2 vediv", vediv, m_ediv);
        chk("R7 vstart", vstart, m_vstart);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_illegal", rsp_illegal, 0);
        chk("R1 rsp_vl", rsp_vl, 0);
        chk("R1 vl", vl, 0);
        chk("R1 vstart", vstart, 0);
        chk("R1 vtype", {vsew, vlmul, vediv}, 0);

        // R3 worked example: SEW=32 (code 2), LMUL=1 (code 0)
        do_req(11'b000_0000_1000, 32'd1000);
        chk("R3 vlmax example", vl, 16);

        // R2 R3 R4 R6 full sweep of immediates and AVL boundaries
        for (int i = 0; i < 128; i++) begin
            longint vm;
            vm = max_len(int'(i[4:2]), int'(i[1:0]));
            do_req(11'(i), 32'd0);
            do_req(11'(i), 32'd1);
            do_req(11'(i), XLEN'(vm - 1));
            do_req(11'(i), XLEN'(vm));
            do_req(11'(i), XLEN'(vm + 1));
            do_req(11'(i), '1);
        end

        // R2 upper immediate bits ignored
        for (int h = 1; h < 16; h++) begin
            do_req({4'(h), 7'b010_0101}, 32'd100);
            chk("R2 upper bits ignored vl", vl, 64 < 100 ? 64 : 100);
        end

        // R9 idle hold
        do_req(11'b000_0101, 32'd7);
        repeat (4) @(negedge clk);
        chk("R9 rsp_valid low", rsp_valid, 0);
        chk("R9 vl held", vl, 7);
        chk("R9 rsp_vl held", rsp_vl, 7);
        chk("R9 vsew held", vsew, 1);

        // R8 vstart load
        vstart_wr = 1'b1; vstart_val = VL_W'(5);
        @(negedge clk);
        vstart_wr = 1'b0;
        chk("R8 vstart loaded", vstart, 5);
        m_vstart = 5;
        // R6 illegal keeps vstart
        do_req(11'b001_0000, 32'd9);
        chk("R6 vstart kept", vstart, 5);
        // R7 legal clears it
        do_req(11'b000_0100, 32'd9);
        chk("R7 vstart cleared", vstart, 0);
        // R7 priority over simultaneous write
        vstart_wr = 1'b1; vstart_val = VL_W'(9);
        do_req(11'b000_0000, 32'd3);
        vstart_wr = 1'b0;
        chk("R7 request wins over write", vstart, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule